// File: doc/BRIEF.md
# Data Translation Fault Status Unit

This block sits beside the data translation buffer of a load/store pipeline. For each data access it takes the virtual address, the access attributes and the result of the buffer lookup. In the same cycle it returns a physical address and a fault code. The unit first picks the privilege mode the access is checked under. It then decides between an untranslated access, a direct-mapped large-page window, an ill-formed address, a lookup miss, a protection or fault-on-access trap, and a hit. A hit above the implemented physical range is flagged as a machine check.

When an access faults in any way other than a machine check, three registers are loaded on the next clock edge. They hold the faulting virtual address, a packed status word and a formatted table address. The status word carries the opcode, the destination register and six cause flags. The formatted address points the miss handler at the page-table slot. After a capture the registers are locked, and later faults leave them untouched. Reading the address register (the `va_rd` strobe) releases the lock in that same cycle. A fault that arrives in the same cycle as the read is therefore captured at that edge and shows on the following cycle.

Top module: `dtfs_unit`

## Requirements
- R1: The effective mode is `cur_mode` when `pc_priv` is 0. When `pc_priv` is 1, it is `alt_mode` if `use_alt` is 1 and kernel otherwise. Mode encoding: 0 kernel, 1 executive, 2 supervisor, 3 user. Bit n of `tlb_rd_en` and `tlb_wr_en` grants mode n.
- R2: With `is_phys` set, `paddr` equals `vaddr` and no translation check applies. `fault_code` is 0, or 5 (machine check) if any `paddr` bit at or above PA_IMPL is set. Fault codes: 0 none, 1 access violation, 2 translation fault, 3 miss, 4 page-table-entry miss, 5 machine check.
- R3: When `spage_en` is set and `vaddr[VA_IMPL-1:VA_IMPL-2]` is 2'b10, the window is taken. If `cur_mode` is kernel, `paddr` is `vaddr[PA_IMPL-1:0]` zero-extended with code 0. Otherwise the code is 1 and the cause is access-violation, plus write on a store.
- R4: An address whose bits VA_W-1 down to VA_IMPL-1 are neither all zero nor all one gives code 2. Its cause is bad-address and access-violation, plus write on a store. Cause bits: 0 write, 1 access-violation, 2 fault-on-read, 3 fault-on-write, 4 bad-address, 5 miss.
- R5: A lookup miss (`tlb_hit` low) sets the miss cause, plus write on a store. It gives code 4 when `is_pte` is set and code 3 otherwise.
- R6: On a store whose effective-mode write-enable bit is clear, the code is 2 and the cause is write and access-violation, plus fault-on-write if `tlb_fonw` is set. If the write is permitted but `tlb_fonw` is set, the code is 2 and the cause is write and fault-on-write.
- R7: On a load whose effective-mode read-enable bit is clear, the code is 1 and the cause is access-violation, plus fault-on-read if `tlb_fonr` is set. If the read is permitted but `tlb_fonr` is set, the code is 2 and the cause is fault-on-read alone.
- R8: On a hit, `paddr` is `{tlb_pfn, vaddr[PAGE_W-1:0]}`. A bit of it at or above PA_IMPL gives code 5, and a machine check loads no status register.
- R9: A captured fault loads `fault_va` with `vaddr` and `mm_stat` with {opcode[5:0] at 16:11, dest_reg[4:0] at 10:6, cause[5:0] at 5:0}. It loads `va_form` with `tbase` ORed with `vaddr[VA_IMPL-1:PAGE_W]` shifted left by 3.
- R10: A fault with code 1 to 4 and `req_valid` high is captured while unlocked and sets `locked`. While locked, faults leave all three registers unchanged. `va_rd` clears `locked` at the same edge. A fault present in the read cycle is captured at that edge.
- R11: After reset the three registers are zero and `locked` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| vaddr | input | VA_W | Virtual address |
| is_write | input | 1 | Access is a store |
| is_phys | input | 1 | Untranslated access |
| use_alt | input | 1 | Use the alternate mode while privileged |
| is_pte | input | 1 | Access is itself a page-table-entry fetch |
| pc_priv | input | 1 | Low PC bit: set while running privileged code |
| cur_mode | input | 2 | Current mode register |
| alt_mode | input | 2 | Alternate mode register |
| spage_en | input | 1 | Direct-mapped window enable |
| opcode | input | 6 | Opcode of the access |
| dest_reg | input | 5 | Destination register number |
| tbase | input | VA_W | Page-table base for the formatted address |
| tlb_hit | input | 1 | Lookup found a matching entry |
| tlb_pfn | input | PA_W-PAGE_W | Page frame number of the entry |
| tlb_rd_en | input | 4 | Per-mode read enables of the entry |
| tlb_wr_en | input | 4 | Per-mode write enables of the entry |
| tlb_fonr | input | 1 | Entry fault-on-read |
| tlb_fonw | input | 1 | Entry fault-on-write |
| va_rd | input | 1 | Fault address register is being read |
| paddr | output | PA_W | Physical address |
| fault_code | output | 3 | Fault code |
| fault_va | output | VA_W | Captured faulting address |
| mm_stat | output | 17 | Captured status word |
| va_form | output | VA_W | Captured formatted table address |
| locked | output | 1 | Status registers are locked |

## Verification
The bench uses the defaults: a 48-bit address with 43 implemented bits, 8 KiB pages and 40 implemented physical bits. These values leave room above the implemented physical range. A large page frame number or an untranslated address can therefore reach the machine check, and a sign-broken virtual address can reach the bad-address path. The scoreboard keeps its own copy of the three status registers and the lock. This lets it check that locking holds the registers through a later fault. It also checks the edge where a read and a new fault fall in the same cycle.

// File: rtl/dtfs_pkg.sv
// Shared encodings for the data translation fault status unit.
// Assumes four privilege modes and a six-bit cause field.
package dtfs_pkg;
    typedef enum logic [1:0] {
        MODE_KERN = 2'd0,
        MODE_EXEC = 2'd1,
        MODE_SUPV = 2'd2,
        MODE_USER = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        FC_NONE    = 3'd0,
        FC_ACCV    = 3'd1,
        FC_XLAT    = 3'd2,
        FC_MISS    = 3'd3,
        FC_MISS_PT = 3'd4,
        FC_MCHK    = 3'd5
    } fcode_e;

    localparam int CB_WR    = 0;
    localparam int CB_ACV   = 1;
    localparam int CB_FOR   = 2;
    localparam int CB_FOW   = 3;
    localparam int CB_BADVA = 4;
    localparam int CB_MISS  = 5;

    localparam int CAUSE_W = 6;
    localparam int OPC_W   = 6;
    localparam int REG_W   = 5;
    localparam int STAT_W  = OPC_W + REG_W + CAUSE_W;
    localparam int MODE_N  = 4;
endpackage

// File: rtl/dtfs_mode_sel.sv
// Effective-mode selection. Privileged code runs in kernel mode unless the
// alternate-mode flag redirects it to the alternate mode register.
// Assumes all inputs are stable within the cycle (purely combinational).
module dtfs_mode_sel
    import dtfs_pkg::*;
(
    input  logic       pc_priv,
    input  logic       use_alt,
    input  logic [1:0] cur_mode,
    input  logic [1:0] alt_mode,
    output logic [1:0] eff_mode
);
    // pick the mode the permission bits are indexed with
    always_comb begin
        if (!pc_priv)
            eff_mode = cur_mode;
        else if (use_alt)
            eff_mode = alt_mode;
        else
            eff_mode = MODE_KERN;
    end
endmodule

// File: rtl/dtfs_check.sv
// Access classification: untranslated, direct-mapped window, ill-formed
// address, miss, permission and fault-on-access traps, hit, machine check.
// Assumes PA_W <= VA_W and PA_IMPL <= VA_IMPL - 2 (window fits the range).
module dtfs_check
    import dtfs_pkg::*;
#(
    parameter int VA_W    = 48,
    parameter int VA_IMPL = 43,
    parameter int PAGE_W  = 13,
    parameter int PA_W    = 48,
    parameter int PA_IMPL = 40
) (
    input  logic [VA_W-1:0]        vaddr,
    input  logic                   is_write,
    input  logic                   is_phys,
    input  logic                   is_pte,
    input  logic                   spage_en,
    input  logic [1:0]             cur_mode,
    input  logic [1:0]             eff_mode,
    input  logic                   tlb_hit,
    input  logic [PA_W-PAGE_W-1:0] tlb_pfn,
    input  logic [MODE_N-1:0]      tlb_rd_en,
    input  logic [MODE_N-1:0]      tlb_wr_en,
    input  logic                   tlb_fonr,
    input  logic                   tlb_fonw,
    output logic [PA_W-1:0]        paddr,
    output logic [2:0]             fcode,
    output logic [CAUSE_W-1:0]     cause,
    output logic                   records
);
    localparam int HI_W = VA_W - VA_IMPL + 1;

    logic [HI_W-1:0] va_hi;
    logic            va_ok;
    logic            in_window;
    fcode_e          code;

    assign va_hi     = vaddr[VA_W-1:VA_IMPL-1];
    assign va_ok     = (&va_hi) | ~(|va_hi);
    assign in_window = spage_en && (vaddr[VA_IMPL-1:VA_IMPL-2] == 2'b10);

    // prioritised decision of address and fault cause
    always_comb begin
        paddr = '0;
        code  = FC_NONE;
        cause = '0;
        if (is_phys) begin
            paddr = vaddr[PA_W-1:0];
        end else if (in_window) begin
            if (cur_mode != MODE_KERN) begin
                code          = FC_ACCV;
                cause[CB_ACV] = 1'b1;
                cause[CB_WR]  = is_write;
            end else begin
                paddr = PA_W'(vaddr[PA_IMPL-1:0]);
            end
        end else if (!va_ok) begin
            code            = FC_XLAT;
            cause[CB_BADVA] = 1'b1;
            cause[CB_ACV]   = 1'b1;
            cause[CB_WR]    = is_write;
        end else if (!tlb_hit) begin
            code           = is_pte ? FC_MISS_PT : FC_MISS;
            cause[CB_MISS] = 1'b1;
            cause[CB_WR]   = is_write;
        end else begin
            paddr = {tlb_pfn, vaddr[PAGE_W-1:0]};
            if (is_write) begin
                if (!tlb_wr_en[eff_mode]) begin
                    code          = FC_XLAT;
                    cause[CB_WR]  = 1'b1;
                    cause[CB_ACV] = 1'b1;
                    cause[CB_FOW] = tlb_fonw;
                end else if (tlb_fonw) begin
                    code          = FC_XLAT;
                    cause[CB_WR]  = 1'b1;
                    cause[CB_FOW] = 1'b1;
                end
            end else begin
                if (!tlb_rd_en[eff_mode]) begin
                    code          = FC_ACCV;
                    cause[CB_ACV] = 1'b1;
                    cause[CB_FOR] = tlb_fonr;
                end else if (tlb_fonr) begin
                    code          = FC_XLAT;
                    cause[CB_FOR] = 1'b1;
                end
            end
        end
        if (code == FC_NONE && (|paddr[PA_W-1:PA_IMPL]))
            code = FC_MCHK;
    end

    assign fcode   = code;
    assign records = (code != FC_NONE) && (code != FC_MCHK);
endmodule

// File: rtl/dtfs_stat_regs.sv
// Fault address, status word and formatted address registers with the
// read-released lock. Assumes va_rd is a single-cycle read strobe.
module dtfs_stat_regs
    import dtfs_pkg::*;
#(
    parameter int VA_W    = 48,
    parameter int VA_IMPL = 43,
    parameter int PAGE_W  = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rec_req,
    input  logic               va_rd,
    input  logic [VA_W-1:0]    vaddr,
    input  logic [OPC_W-1:0]   opcode,
    input  logic [REG_W-1:0]   dest_reg,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [VA_W-1:0]    tbase,
    output logic [VA_W-1:0]    fault_va,
    output logic [STAT_W-1:0]  mm_stat,
    output logic [VA_W-1:0]    va_form,
    output logic               locked
);
    localparam int VPN_W = VA_IMPL - PAGE_W;

    logic            capture;
    logic [VA_W-1:0] vpn_slot;

    assign capture  = rec_req && (!locked || va_rd);
    assign vpn_slot = VA_W'(vaddr[VA_IMPL-1:PAGE_W]) << 3;

    // load the registers on an unlocked fault and track the lock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_va <= '0;
            mm_stat  <= '0;
            va_form  <= '0;
            locked   <= 1'b0;
        end else begin
            if (capture) begin
                fault_va <= vaddr;
                mm_stat  <= {opcode, dest_reg, cause};
                va_form  <= tbase | vpn_slot;
            end
            locked <= capture | (locked & ~va_rd);
        end
    end
endmodule

// File: rtl/dtfs_unit.sv
// Top of the data translation fault status unit: mode selection, access
// classification and the locked status registers.
// Assumes the lookup result belongs to the address presented this cycle.
module dtfs_unit
    import dtfs_pkg::*;
#(
    parameter int VA_W    = 48,
    parameter int VA_IMPL = 43,
    parameter int PAGE_W  = 13,
    parameter int PA_W    = 48,
    parameter int PA_IMPL = 40
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [VA_W-1:0]        vaddr,
    input  logic                   is_write,
    input  logic                   is_phys,
    input  logic                   use_alt,
    input  logic                   is_pte,
    input  logic                   pc_priv,
    input  logic [1:0]             cur_mode,
    input  logic [1:0]             alt_mode,
    input  logic                   spage_en,
    input  logic [5:0]             opcode,
    input  logic [4:0]             dest_reg,
    input  logic [VA_W-1:0]        tbase,
    input  logic                   tlb_hit,
    input  logic [PA_W-PAGE_W-1:0] tlb_pfn,
    input  logic [3:0]             tlb_rd_en,
    input  logic [3:0]             tlb_wr_en,
    input  logic                   tlb_fonr,
    input  logic                   tlb_fonw,
    input  logic                   va_rd,
    output logic [PA_W-1:0]        paddr,
    output logic [2:0]             fault_code,
    output logic [VA_W-1:0]        fault_va,
    output logic [16:0]            mm_stat,
    output logic [VA_W-1:0]        va_form,
    output logic                   locked
);
    logic [1:0]         eff_mode;
    logic [CAUSE_W-1:0] cause;
    logic               records;

    dtfs_mode_sel u_mode (
        .pc_priv  (pc_priv),
        .use_alt  (use_alt),
        .cur_mode (cur_mode),
        .alt_mode (alt_mode),
        .eff_mode (eff_mode)
    );

    dtfs_check #(
        .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PAGE_W(PAGE_W),
        .PA_W(PA_W), .PA_IMPL(PA_IMPL)
    ) u_check (
        .vaddr     (vaddr),
        .is_write  (is_write),
        .is_phys   (is_phys),
        .is_pte    (is_pte),
        .spage_en  (spage_en),
        .cur_mode  (cur_mode),
        .eff_mode  (eff_mode),
        .tlb_hit   (tlb_hit),
        .tlb_pfn   (tlb_pfn),
        .tlb_rd_en (tlb_rd_en),
        .tlb_wr_en (tlb_wr_en),
        .tlb_fonr  (tlb_fonr),
        .tlb_fonw  (tlb_fonw),
        .paddr     (paddr),
        .fcode     (fault_code),
        .cause     (cause),
        .records   (records)
    );

    dtfs_stat_regs #(
        .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PAGE_W(PAGE_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rec_req  (req_valid & records),
        .va_rd    (va_rd),
        .vaddr    (vaddr),
        .opcode   (opcode),
        .dest_reg (dest_reg),
        .cause    (cause),
        .tbase    (tbase),
        .fault_va (fault_va),
        .mm_stat  (mm_stat),
        .va_form  (va_form),
        .locked   (locked)
    );
endmodule

// File: rtl/dtfs_unit_chk.sv
// Property checker for dtfs_unit, attached by bind. Observes ports only.
module dtfs_unit_chk #(
    parameter int VA_W = 48,
    parameter int PA_W = 48
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] vaddr,
    input logic            is_write,
    input logic            is_phys,
    input logic [5:0]      opcode,
    input logic [4:0]      dest_reg,
    input logic            va_rd,
    input logic [PA_W-1:0] paddr,
    input logic [2:0]      fault_code,
    input logic [VA_W-1:0] fault_va,
    input logic [16:0]     mm_stat,
    input logic [VA_W-1:0] va_form,
    input logic            locked
);
    logic fault_in;
    logic take;

    assign fault_in = req_valid && (fault_code >= 3'd1) && (fault_code <= 3'd4);
    assign take     = fault_in && (!locked || va_rd);

    // R10: a held lock without a read freezes the registers
    p_lock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        locked && !va_rd |=> locked && $stable(fault_va) && $stable(mm_stat) && $stable(va_form));

    // R10: an accepted fault locks and records the address
    p_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> locked && (fault_va == $past(vaddr)));

    // R10: a read with no new fault releases the lock
    p_read_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        va_rd && !fault_in |=> !locked);

    // R9: status word carries opcode and destination register
    p_stat_pack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> mm_stat[16:6] == {$past(opcode), $past(dest_reg)});

    // R6: a captured store fault has the write cause bit
    p_store_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take && is_write |=> mm_stat[0]);

    // R8: a machine check never locks the registers
    p_mchk_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && fault_code == 3'd5 && !locked |=> !locked);

    // R2: untranslated accesses without fault pass the address through
    p_phys_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_phys && fault_code == 3'd0 |-> paddr == vaddr[PA_W-1:0]);
endmodule

bind dtfs_unit dtfs_unit_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .vaddr      (vaddr),
    .is_write   (is_write),
    .is_phys    (is_phys),
    .opcode     (opcode),
    .dest_reg   (dest_reg),
    .va_rd      (va_rd),
    .paddr      (paddr),
    .fault_code (fault_code),
    .fault_va   (fault_va),
    .mm_stat    (mm_stat),
    .va_form    (va_form),
    .locked     (locked)
);

// File: tb/dtfs_unit_tb_top.sv
`timescale 1ns/1ps
module dtfs_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid, is_write, is_phys, use_alt, is_pte, pc_priv, spage_en;
    logic [47:0] vaddr, tbase;
    logic [1:0]  cur_mode, alt_mode;
    logic [5:0]  opcode;
    logic [4:0]  dest_reg;
    logic        tlb_hit, tlb_fonr, tlb_fonw, va_rd;
    logic [34:0] tlb_pfn;
    logic [3:0]  tlb_rd_en, tlb_wr_en;
    logic [47:0] paddr, fault_va, va_form;
    logic [2:0]  fault_code;
    logic [16:0] mm_stat;
    logic        locked;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct {
        logic [2:0]  code;
        logic [47:0] pa;
        bit          chk_code;
        bit          chk_pa;
        logic [47:0] va;
        logic [47:0] form;
        logic [16:0] stat;
        bit          lock;
        string       tag;
    } item_t;

    item_t q[$];
    logic [47:0] m_va = '0, m_form = '0;
    logic [16:0] m_stat = '0;
    bit          m_lock = 0;

    always #2 clk = ~clk;

    dtfs_unit dut_i (.*);

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic defaults();
        req_valid = 1; is_write = 0; is_phys = 0; use_alt = 0; is_pte = 0;
        pc_priv = 0; spage_en = 0; cur_mode = 2'd3; alt_mode = 2'd0;
        vaddr = 48'h0000_1234_5678; tbase = 48'h4000_0000_0000;
        opcode = 6'h29; dest_reg = 5'h0a;
        tlb_hit = 1; tlb_pfn = 35'h12345; tlb_rd_en = 4'hF; tlb_wr_en = 4'hF;
        tlb_fonr = 0; tlb_fonw = 0; va_rd = 0;
    endtask

    // driver: update the reference registers and queue the expectation
    task automatic go(input logic [2:0] ec, input logic [5:0] ecause,
                      input logic [47:0] epa, input bit cpa, input string tag);
        item_t it;
        bit rec;
        rec = req_valid && (ec >= 3'd1) && (ec <= 3'd4);
        if (rec && (!m_lock || va_rd)) begin
            m_va   = vaddr;
            m_stat = {opcode, dest_reg, ecause};
            m_form = tbase | ({18'd0, vaddr[42:13]} << 3);
            m_lock = 1;
        end else if (va_rd) begin
            m_lock = 0;
        end
        it.code = ec; it.pa = epa; it.chk_code = req_valid; it.chk_pa = cpa;
        it.va = m_va; it.form = m_form; it.stat = m_stat; it.lock = m_lock;
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic step();
        @(negedge clk);
        defaults();
    endtask

    task automatic rd();
        step();
        req_valid = 0; va_rd = 1;
        go(3'd0, 6'd0, '0, 0, "R10");
    endtask

    // monitor: sample one ns after the edge, compare against the queue
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                if (it.chk_code)
                    check(fault_code == it.code, it.tag, "fault_code", 64'(fault_code), 64'(it.code));
                if (it.chk_pa)
                    check(paddr == it.pa, it.tag, "paddr", 64'(paddr), 64'(it.pa));
                check(fault_va == it.va, it.tag, "fault_va", 64'(fault_va), 64'(it.va));
                check(mm_stat == it.stat, it.tag, "mm_stat", 64'(mm_stat), 64'(it.stat));
                check(va_form == it.form, it.tag, "va_form", 64'(va_form), 64'(it.form));
                check(locked == it.lock, it.tag, "locked", 64'(locked), 64'(it.lock));
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        defaults();
        req_valid = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        check(fault_va == 0 && mm_stat == 0 && va_form == 0, "R11", "regs", 64'(mm_stat), 0);
        check(locked == 0, "R11", "locked", 64'(locked), 0);

        // R8: plain hit, user load
        step(); go(3'd0, 6'd0, {35'h12345, 13'h1678}, 1, "R8");
        // R8: frame above implemented range -> machine check, no capture
        step(); tlb_pfn = 35'h4_0000_0000;
        go(3'd5, 6'd0, {35'h4_0000_0000, 13'h1678}, 1, "R8");
        // R2: untranslated in range and out of range
        step(); is_phys = 1; vaddr = 48'h00AB_CDEF_0123;
        go(3'd0, 6'd0, 48'h00AB_CDEF_0123, 1, "R2");
        step(); is_phys = 1; vaddr = 48'h0100_0000_0040;
        go(3'd5, 6'd0, 48'h0100_0000_0040, 1, "R2");
        // R3: window in kernel mode, then from user mode
        step(); spage_en = 1; cur_mode = 2'd0; vaddr = 48'hFC00_1234_5678;
        go(3'd0, 6'd0, 48'h0000_1234_5678, 1, "R3");
        step(); spage_en = 1; vaddr = 48'hFC00_1234_5678;
        go(3'd1, 6'h02, '0, 0, "R3");
        rd();
        // R4: ill-formed store address
        step(); is_write = 1; vaddr = 48'h0800_0000_0000;
        go(3'd2, 6'h13, '0, 0, "R4");
        // R10: locked, a miss is not captured
        step(); tlb_hit = 0; opcode = 6'h11; vaddr = 48'h0000_0000_6000;
        go(3'd3, 6'h20, '0, 0, "R10");
        // R5 + R10: read and page-table store miss in the same cycle
        step(); va_rd = 1; tlb_hit = 0; is_write = 1; is_pte = 1; vaddr = 48'h0000_0777_E000;
        go(3'd4, 6'h21, '0, 0, "R5");
        rd();
        // R5: ordinary load miss
        step(); tlb_hit = 0; vaddr = 48'hFFFF_FFFF_E000;
        go(3'd3, 6'h20, '0, 0, "R5");
        rd();
        // R6: store without user write permission, fault-on-write set
        step(); is_write = 1; tlb_wr_en = 4'b0111; tlb_fonw = 1;
        go(3'd2, 6'h0B, {35'h12345, 13'h1678}, 1, "R6");
        rd();
        // R6: store permitted but fault-on-write set
        step(); is_write = 1; tlb_fonw = 1; dest_reg = 5'h1f;
        go(3'd2, 6'h09, {35'h12345, 13'h1678}, 1, "R6");
        rd();
        // R7: load without read permission, fault-on-read set
        step(); tlb_rd_en = 4'b0111; tlb_fonr = 1;
        go(3'd1, 6'h06, {35'h12345, 13'h1678}, 1, "R7");
        rd();
        // R7: load permitted, fault-on-read set
        step(); tlb_fonr = 1; opcode = 6'h3f;
        go(3'd2, 6'h04, {35'h12345, 13'h1678}, 1, "R7");
        rd();
        // R1: privileged code without alternate flag uses kernel
        step(); pc_priv = 1; tlb_rd_en = 4'b0001;
        go(3'd0, 6'd0, {35'h12345, 13'h1678}, 1, "R1");
        // R1: privileged with alternate flag uses alt_mode
        step(); pc_priv = 1; use_alt = 1; alt_mode = 2'd2; tlb_rd_en = 4'b0100;
        go(3'd0, 6'd0, {35'h12345, 13'h1678}, 1, "R1");
        step(); pc_priv = 1; use_alt = 1; alt_mode = 2'd1; tlb_rd_en = 4'b0100;
        go(3'd1, 6'h02, {35'h12345, 13'h1678}, 1, "R1");
        rd();
        // R1: ordinary code uses cur_mode
        step(); cur_mode = 2'd1; use_alt = 1; alt_mode = 2'd3; tlb_rd_en = 4'b0010;
        go(3'd0, 6'd0, {35'h12345, 13'h1678}, 1, "R1");
        // R9: formatted address with a different base
        step(); tlb_hit = 0; tbase = 48'h0000_8000_0000; vaddr = 48'h0000_0ABC_D000;
        go(3'd3, 6'h20, '0, 0, "R9");
        rd();

        step(); req_valid = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule